// File: doc/BRIEF.md
# ATA PIO Host Cycle Sequencer

This block is the host end of a parallel ATA register and data-port interface. Each accepted request becomes one programmed-I/O bus cycle with three phases. In the first, address and chip selects settle. In the second, the read or write strobe is low. In the third, the strobe is high again while address, selects and any write data stay on the bus. The request gives the direction, a 3-bit register address, two chip selects, a flag for 8-bit register access, write data and a transfer mode from 0 to 6.

Every phase length comes from a per-mode nanosecond table. Each value is rounded up to whole clocks with the `CLK_PERIOD_NS` parameter. In modes 0 to 4 the device ready line is sampled a fixed delay after the strobe falls. If ready is low at that moment, the strobe is held low until ready returns. A wait that lasts too long is cut short and reported as an error. The block returns read data and a one-cycle done pulse, and it accepts a new request only while idle.

Top module: `pio_host_seq`

## Requirements
- R1: During and after synchronous reset, the block is idle. Both strobes are high, both active-low chip selects are high, the data bus is not driven, and busy, done and err are low.
- R2: After a request is accepted, `bus_addr` shows the request address and `bus_cs_n` shows the inverse of `req_cs`, for exactly ceil(t1/P) cycles before the strobe falls. P is `CLK_PERIOD_NS`. t1 is 70/50/30/30/25/15/10 ns for modes 0..6. A read lowers only `bus_rd_n` and a write lowers only `bus_wr_n`.
- R3: With no wait state, the strobe stays low for exactly ceil(t2/P) cycles. t2 is 165/125/100/80/70/65/55 ns for modes 0..6. When `req_byte` is 1 in modes 0 to 2, t2 is 290 ns instead.
- R4: After the strobe rises, address and chip selects hold for exactly R cycles. Then done pulses high for one cycle, with the chip selects released. R is the largest of four values:
  - ceil(t2i/P), where t2i is 0/0/0/70/25/25/20 ns for modes 0..6;
  - ceil(t9/P), where t9 is 20/15/10/10/10/10/10 ns;
  - for writes only, ceil(t4/P), where t4 is 30/20/15/10/10/5/5 ns;
  - ceil(t0/P) - ceil(t1/P) - ceil(t2/P), where t0 is 600/383/240/180/120/100/80 ns.
- R5: A write drives `req_wdata` onto the bus, with `bus_doe` high, from address valid until the end of the hold phase. A read never raises `bus_doe`.
- R6: In modes 0 to 4, `bus_rdy` is sampled ceil(35/P) cycles after the strobe falls. If it is low, the strobe stays low until it is seen high, and falls back no earlier than the R3 width. If it is high at the sample, no wait is added, even if it was low earlier.
- R7: In modes 5 and 6, `bus_rdy` has no effect. Mode code 7 behaves as mode 6.
- R8: When a wait occurs on a read, `rd_data` captures the bus in the cycle where ready is first seen high. Without a wait, it captures the bus as the strobe rises. In 8-bit cycles, `rd_data[15:8]` reads as zero.
- R9: If ready is still low ceil(1250/P) cycles after the sample, the strobe rises anyway and the cycle finishes normally. err is then high together with done, and `rd_data` keeps its previous value.
- R10: busy is high from acceptance until the cycle ends. A request offered while busy is ignored: the bus address does not change and no further cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offer, taken when idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 3 | Register address |
| req_cs | input | 2 | Chip selects, active high |
| req_byte | input | 1 | 8-bit register access |
| req_wdata | input | 16 | Write data |
| req_mode | input | 3 | PIO mode 0..6 (7 treated as 6) |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready timeout, valid with done |
| rd_data | output | 16 | Captured read data |
| bus_addr | output | 3 | Device address lines |
| bus_cs_n | output | 2 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | 16 | Data driven toward the device |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 16 | Data from the device |
| bus_rdy | input | 1 | Device ready line |

## Verification
The hardest situations to reach from the ports depend on the device ready line at particular strobe-low cycles.

- For a real wait, the bench holds ready low through the sample point and releases it at a chosen strobe-low count. It then changes the device data one cycle later, so the capture cycle shows up in `rd_data`.
- For the no-wait case, ready is released before the sample point.
- For the timeout, ready is never released. The bench confirms that the error arrives at sample delay plus limit, and that the earlier read value survives.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int CS_W   = 2;
    localparam int MODE_W = 3;
    localparam int CNT_W  = 16;
    localparam int TOP_MODE = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOV
    } pio_state_e;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [CS_W-1:0]   cs;
        logic              is8;
        logic [DATA_W-1:0] wdata;
        logic [MODE_W-1:0] mode;
    } pio_req_t;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
        logic [CNT_W-1:0] rdy_at;
        logic [CNT_W-1:0] rdy_lim;
        logic             use_rdy;
    } pio_timing_t;

    function automatic int ns2clk(input int ns, input int period);
        if (ns <= 0) return 0;
        return (ns + period - 1) / period;
    endfunction

    function automatic int cyc_ns(input int m);
        case (m)
            0: return 600; 1: return 383; 2: return 240; 3: return 180;
            4: return 120; 5: return 100; default: return 80;
        endcase
    endfunction

    function automatic int setup_ns(input int m);
        case (m)
            0: return 70; 1: return 50; 2: return 30; 3: return 30;
            4: return 25; 5: return 15; default: return 10;
        endcase
    endfunction

    function automatic int width_ns(input int m, input logic byte_access);
        if (byte_access && m <= 2) return 290;
        case (m)
            0: return 165; 1: return 125; 2: return 100; 3: return 80;
            4: return 70; 5: return 65; default: return 55;
        endcase
    endfunction

    function automatic int recov_ns(input int m);
        case (m)
            3: return 70; 4: return 25; 5: return 25; 6: return 20;
            default: return 0;
        endcase
    endfunction

    function automatic int wr_hold_ns(input int m);
        case (m)
            0: return 30; 1: return 20; 2: return 15; 3: return 10;
            4: return 10; default: return 5;
        endcase
    endfunction

    function automatic int addr_hold_ns(input int m);
        case (m)
            0: return 20; 1: return 15; default: return 10;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] fmt_read(input logic [DATA_W-1:0] din,
                                                   input logic byte_access);
        if (byte_access) return {{(DATA_W-8){1'b0}}, din[7:0]};
        return din;
    endfunction

endpackage

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
    import ata_pio_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int RDY_SAMPLE_NS = 35,
    parameter int RDY_LIMIT_NS  = 1250
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              is8,
    input  logic              write,
    output pio_timing_t       tim
);
    localparam int SAMPLE_C = ns2clk(RDY_SAMPLE_NS, CLK_PERIOD_NS);
    localparam int LIMIT_C  = ns2clk(RDY_LIMIT_NS, CLK_PERIOD_NS);

    int m_eff;
    int c_cyc;
    int c_set;
    int c_act;
    int c_rec;

    always_comb begin
        m_eff = (int'(mode) > TOP_MODE) ? TOP_MODE : int'(mode);
        c_cyc = ns2clk(cyc_ns(m_eff), CLK_PERIOD_NS);
        c_set = ns2clk(setup_ns(m_eff), CLK_PERIOD_NS);
        c_act = ns2clk(width_ns(m_eff, is8), CLK_PERIOD_NS);
        c_rec = ns2clk(recov_ns(m_eff), CLK_PERIOD_NS);
        if (ns2clk(addr_hold_ns(m_eff), CLK_PERIOD_NS) > c_rec)
            c_rec = ns2clk(addr_hold_ns(m_eff), CLK_PERIOD_NS);
        if (write && ns2clk(wr_hold_ns(m_eff), CLK_PERIOD_NS) > c_rec)
            c_rec = ns2clk(wr_hold_ns(m_eff), CLK_PERIOD_NS);
        if (c_cyc - c_set - c_act > c_rec)
            c_rec = c_cyc - c_set - c_act;
        if (c_rec < 1) c_rec = 1;

        tim.setup   = CNT_W'(c_set);
        tim.active  = CNT_W'(c_act);
        tim.recov   = CNT_W'(c_rec);
        tim.rdy_at  = CNT_W'(SAMPLE_C);
        tim.rdy_lim = CNT_W'(LIMIT_C);
        tim.use_rdy = (m_eff <= 4);
    end
endmodule

// File: rtl/pio_wait_ctl.sv
module pio_wait_ctl
    import ata_pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_clr,
    input  logic             sample_now,
    input  logic             use_rdy,
    input  logic             rdy,
    input  logic [CNT_W-1:0] limit,
    output logic             pending,
    output logic             release_now,
    output logic             timeout_now
);
    logic             wait_q;
    logic [CNT_W-1:0] wd_q;
    logic             start_wait;

    assign start_wait  = sample_now & use_rdy & ~rdy & ~wait_q;
    assign release_now = wait_q & rdy;
    assign timeout_now = wait_q & ~rdy & (wd_q == limit - 1'b1);
    assign pending     = wait_q | start_wait;

    always_ff @(posedge clk) begin
        if (rst || arm_clr) begin
            wait_q <= 1'b0;
            wd_q   <= '0;
        end else if (start_wait) begin
            wait_q <= 1'b1;
            wd_q   <= '0;
        end else if (wait_q) begin
            if (release_now || timeout_now) wait_q <= 1'b0;
            else                            wd_q   <= wd_q + 1'b1;
        end
    end
endmodule

// File: rtl/pio_host_seq.sv
module pio_host_seq
    import ata_pio_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int RDY_SAMPLE_NS = 35,
    parameter int RDY_LIMIT_NS  = 1250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CS_W-1:0]   req_cs,
    input  logic              req_byte,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MODE_W-1:0] req_mode,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [CS_W-1:0]   bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_rdy
);
    pio_state_e        state_q;
    pio_req_t          req_q;
    pio_timing_t       tim;
    logic [CNT_W-1:0]  cnt_q;
    logic              got_q;
    logic              err_q;
    logic              done_q;
    logic [DATA_W-1:0] rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CS_W-1:0]   cs_n_q;
    logic              rd_n_q;
    logic              wr_n_q;
    logic [DATA_W-1:0] dout_q;
    logic              doe_q;

    logic sample_now;
    logic pending;
    logic release_now;
    logic timeout_now;

    pio_timing_calc #(
        .CLK_PERIOD_NS (CLK_PERIOD_NS),
        .RDY_SAMPLE_NS (RDY_SAMPLE_NS),
        .RDY_LIMIT_NS  (RDY_LIMIT_NS)
    ) timing_i (
        .mode  (req_q.mode),
        .is8   (req_q.is8),
        .write (req_q.write),
        .tim   (tim)
    );

    assign sample_now = (state_q == ST_ACTIVE) && (cnt_q == tim.rdy_at - 1'b1);

    pio_wait_ctl wait_i (
        .clk         (clk),
        .rst         (rst),
        .arm_clr     (state_q != ST_ACTIVE),
        .sample_now  (sample_now),
        .use_rdy     (tim.use_rdy),
        .rdy         (bus_rdy),
        .limit       (tim.rdy_lim),
        .pending     (pending),
        .release_now (release_now),
        .timeout_now (timeout_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            cnt_q   <= '0;
            got_q   <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            rd_q    <= '0;
            addr_q  <= '0;
            cs_n_q  <= '1;
            rd_n_q  <= 1'b1;
            wr_n_q  <= 1'b1;
            dout_q  <= '0;
            doe_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q   <= '{write: req_write, addr: req_addr, cs: req_cs,
                                     is8: req_byte, wdata: req_wdata, mode: req_mode};
                        state_q <= ST_SETUP;
                        cnt_q   <= '0;
                        got_q   <= 1'b0;
                        err_q   <= 1'b0;
                        addr_q  <= req_addr;
                        cs_n_q  <= ~req_cs;
                        dout_q  <= req_write ? req_wdata : '0;
                        doe_q   <= req_write;
                    end
                end
                ST_SETUP: begin
                    if (cnt_q == tim.setup - 1'b1) begin
                        state_q <= ST_ACTIVE;
                        cnt_q   <= '0;
                        if (req_q.write) wr_n_q <= 1'b0;
                        else             rd_n_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (timeout_now) begin
                        rd_n_q  <= 1'b1;
                        wr_n_q  <= 1'b1;
                        err_q   <= 1'b1;
                        state_q <= ST_RECOV;
                        cnt_q   <= '0;
                    end else begin
                        if (release_now && !req_q.write) begin
                            rd_q  <= fmt_read(bus_din, req_q.is8);
                            got_q <= 1'b1;
                        end
                        if ((cnt_q >= tim.active - 1'b1) && !pending) begin
                            rd_n_q  <= 1'b1;
                            wr_n_q  <= 1'b1;
                            state_q <= ST_RECOV;
                            cnt_q   <= '0;
                            if (!req_q.write && !got_q)
                                rd_q <= fmt_read(bus_din, req_q.is8);
                        end
                    end
                end
                ST_RECOV: begin
                    if (cnt_q == tim.recov - 1'b1) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                        cs_n_q  <= '1;
                        addr_q  <= '0;
                        dout_q  <= '0;
                        doe_q   <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign err      = done_q & err_q;
    assign rd_data  = rd_q;
    assign bus_addr = addr_q;
    assign bus_cs_n = cs_n_q;
    assign bus_rd_n = rd_n_q;
    assign bus_wr_n = wr_n_q;
    assign bus_dout = dout_q;
    assign bus_doe  = doe_q;
endmodule

// File: rtl/pio_host_seq_chk.sv
module pio_host_seq_chk
    import ata_pio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CS_W-1:0]   bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              bus_doe
);
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n));

    a_r2_strobe_needs_cs: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || !bus_wr_n) |-> (bus_cs_n != '1));

    a_r5_read_no_drive: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> !bus_doe);

    a_r5_write_drives: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> bus_doe);

    a_r4_cs_held_after_strobe: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> (bus_cs_n != '1));

    a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
        ((!bus_rd_n || !bus_wr_n) && $past(!bus_rd_n || !bus_wr_n)) |-> $stable(bus_addr));

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r10_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind pio_host_seq pio_host_seq_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .bus_addr (bus_addr),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_doe  (bus_doe)
);

// File: tb/pio_host_seq_tb_top.sv
module pio_host_seq_tb_top;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [1:0]  req_cs = '0;
    logic        req_byte = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [2:0]  req_mode = '0;
    logic        busy, done, err;
    logic [15:0] rd_data;
    logic [2:0]  bus_addr;
    logic [1:0]  bus_cs_n;
    logic        bus_rd_n, bus_wr_n;
    logic [15:0] bus_dout;
    logic        bus_doe;
    logic [15:0] bus_din = '0;
    logic        bus_rdy = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_NS/2) clk = ~clk;

    pio_host_seq #(.CLK_PERIOD_NS(CLK_NS)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_cs(req_cs), .req_byte(req_byte),
        .req_wdata(req_wdata), .req_mode(req_mode), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_rdy(bus_rdy)
    );

    function automatic int cdiv(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction

    function automatic int e_t0(input int m);
        int t[7] = '{600, 383, 240, 180, 120, 100, 80};
        return cdiv(t[m]);
    endfunction
    function automatic int e_t1(input int m);
        int t[7] = '{70, 50, 30, 30, 25, 15, 10};
        return cdiv(t[m]);
    endfunction
    function automatic int e_t2(input int m, input bit b8);
        int t[7] = '{165, 125, 100, 80, 70, 65, 55};
        if (b8 && m <= 2) return cdiv(290);
        return cdiv(t[m]);
    endfunction
    function automatic int e_rec(input int m, input bit wr, input bit b8);
        int t2i[7] = '{0, 0, 0, 70, 25, 25, 20};
        int t4[7]  = '{30, 20, 15, 10, 10, 5, 5};
        int t9[7]  = '{20, 15, 10, 10, 10, 10, 10};
        int r;
        r = cdiv(t2i[m]);
        if (cdiv(t9[m]) > r) r = cdiv(t9[m]);
        if (wr && cdiv(t4[m]) > r) r = cdiv(t4[m]);
        if (e_t0(m) - e_t1(m) - e_t2(m, b8) > r) r = e_t0(m) - e_t1(m) - e_t2(m, b8);
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // rdy_kind: 0 ready always high, 1 low then raised at strobe-low count k, 2 never raised
    task automatic run_cycle(input bit wr, input logic [2:0] addr, input logic [1:0] cs,
                             input bit b8, input logic [15:0] wd, input logic [2:0] mode,
                             input int rdy_kind, input int k,
                             input logic [15:0] d1, input logic [15:0] d2,
                             output int n_set, output int n_low, output int n_hold,
                             output bit got_err, output logic [15:0] got_rd,
                             output bit bad);
        bit seen_low;
        int guard;
        n_set = 0; n_low = 0; n_hold = 0; got_err = 0; got_rd = '0; bad = 0;
        seen_low = 0; guard = 0;
        bus_din = d1;
        bus_rdy = (rdy_kind == 0);
        req_write = wr; req_addr = addr; req_cs = cs; req_byte = b8;
        req_wdata = wd; req_mode = mode; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && guard < 3000) begin
            guard++;
            if ((wr ? bus_rd_n : bus_wr_n) == 1'b0) bad = 1;
            if (!wr && bus_doe) bad = 1;
            if ((wr ? bus_wr_n : bus_rd_n) == 1'b0) begin
                seen_low = 1;
                n_low++;
                if (bus_addr != addr || bus_cs_n != ~cs) bad = 1;
                if (wr && (!bus_doe || bus_dout != wd)) bad = 1;
                if (rdy_kind == 1 && n_low == k) bus_rdy = 1'b1;
                if (rdy_kind == 1 && n_low == k + 1) bus_din = d2;
            end else if (bus_cs_n != 2'b11) begin
                if (bus_addr != addr || bus_cs_n != ~cs) bad = 1;
                if (!seen_low) n_set++;
                else begin
                    n_hold++;
                    if (wr && (!bus_doe || bus_dout != wd)) bad = 1;
                end
            end
            @(negedge clk);
        end
        got_err = err;
        got_rd  = rd_data;
        if (bus_cs_n != 2'b11 || busy) bad = 1;
        @(negedge clk);
        if (done) bad = 1;
        bus_rdy = 1'b1;
    endtask

    task automatic t_reset;
        check("R1 rd_n", bus_rd_n, 1);
        check("R1 wr_n", bus_wr_n, 1);
        check("R1 cs_n", bus_cs_n, 3);
        check("R1 doe", bus_doe, 0);
        check("R1 busy/done/err", {busy, done, err}, 0);
    endtask

    task automatic t_read_m0;
        int s, l, h; bit e, b; logic [15:0] r;
        run_cycle(0, 3'd7, 2'b01, 0, 16'h0, 3'd0, 0, 0, 16'hBEEF, 16'hBEEF, s, l, h, e, r, b);
        check("R2 setup m0", s, e_t1(0));
        check("R3 width m0", l, e_t2(0, 0));
        check("R4 hold m0 read", h, e_rec(0, 0, 0));
        check("R8 read data m0", r, 16'hBEEF);
        check("R5 read bus/strobe", b, 0);
        check("R9 no err", e, 0);
    endtask

    task automatic t_read_byte;
        int s, l, h; bit e, b; logic [15:0] r;
        run_cycle(0, 3'd1, 2'b10, 1, 16'h0, 3'd0, 0, 0, 16'hA55A, 16'hA55A, s, l, h, e, r, b);
        check("R3 8-bit width m0", l, e_t2(0, 1));
        check("R4 hold m0 8-bit", h, e_rec(0, 0, 1));
        check("R8 8-bit upper zero", r, 16'h005A);
        run_cycle(0, 3'd2, 2'b01, 1, 16'h0, 3'd3, 0, 0, 16'h1234, 16'h1234, s, l, h, e, r, b);
        check("R3 8-bit width m3 unstretched", l, e_t2(3, 1));
        check("R4 hold m3", h, e_rec(3, 0, 1));
    endtask

    task automatic t_writes;
        int s, l, h; bit e, b; logic [15:0] r;
        run_cycle(1, 3'd5, 2'b01, 0, 16'hC3A5, 3'd2, 0, 0, 16'h0, 16'h0, s, l, h, e, r, b);
        check("R2 setup m2 write", s, e_t1(2));
        check("R3 width m2 write", l, e_t2(2, 0));
        check("R4 hold m2 write", h, e_rec(2, 1, 0));
        check("R5 write data driven", b, 0);
        run_cycle(1, 3'd0, 2'b10, 0, 16'h5A0F, 3'd6, 0, 0, 16'h0, 16'h0, s, l, h, e, r, b);
        check("R2 setup m6 write", s, e_t1(6));
        check("R3 width m6 write", l, e_t2(6, 0));
        check("R4 hold m6 write", h, e_rec(6, 1, 0));
        check("R5 write m6 bus", b, 0);
    endtask

    task automatic t_wait_read;
        int s, l, h; bit e, b; logic [15:0] r;
        run_cycle(0, 3'd0, 2'b01, 0, 16'h0, 3'd0, 1, 30, 16'h1111, 16'h2222, s, l, h, e, r, b);
        check("R6 waited width", l, 31);
        check("R8 capture at ready return", r, 16'h1111);
        check("R6 waited hold", h, e_rec(0, 0, 0));
        run_cycle(0, 3'd0, 2'b01, 0, 16'h0, 3'd4, 1, 1, 16'h3333, 16'h4444, s, l, h, e, r, b);
        check("R6 early release no wait", l, e_t2(4, 0));
        check("R8 capture at negation", r, 16'h4444);
    endtask

    task automatic t_fast_modes;
        int s, l, h; bit e, b; logic [15:0] r;
        run_cycle(0, 3'd3, 2'b01, 0, 16'h0, 3'd6, 2, 0, 16'h6666, 16'h6666, s, l, h, e, r, b);
        check("R7 m6 ignores ready", l, e_t2(6, 0));
        check("R7 m6 no err", e, 0);
        run_cycle(0, 3'd3, 2'b01, 0, 16'h0, 3'd5, 2, 0, 16'h5555, 16'h5555, s, l, h, e, r, b);
        check("R7 m5 ignores ready", l, e_t2(5, 0));
        run_cycle(0, 3'd3, 2'b01, 0, 16'h0, 3'd7, 0, 0, 16'h7777, 16'h7777, s, l, h, e, r, b);
        check("R7 code7 setup", s, e_t1(6));
        check("R7 code7 width", l, e_t2(6, 0));
        check("R7 code7 hold", h, e_rec(6, 0, 0));
    endtask

    task automatic t_watchdog;
        int s, l, h; bit e, b; logic [15:0] r;
        run_cycle(0, 3'd4, 2'b01, 0, 16'h0, 3'd1, 0, 0, 16'hABCD, 16'hABCD, s, l, h, e, r, b);
        check("R9 prior read", r, 16'hABCD);
        run_cycle(0, 3'd4, 2'b01, 0, 16'h0, 3'd1, 2, 0, 16'hDEAD, 16'hDEAD, s, l, h, e, r, b);
        check("R9 timeout width", l, cdiv(35) + cdiv(1250));
        check("R9 err flagged", e, 1);
        check("R9 rd_data kept", r, 16'hABCD);
        check("R9 hold after abort", h, e_rec(1, 0, 0));
    endtask

    task automatic t_busy_ignore;
        int cyc;
        bit bad;
        bad = 0;
        req_write = 0; req_addr = 3'd2; req_cs = 2'b01; req_byte = 0;
        req_mode = 3'd0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 busy after accept", busy, 1);
        repeat (5) @(negedge clk);
        req_addr = 3'd6; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 3000) begin
            if (bus_addr != 3'd2) bad = 1;
            cyc++;
            @(negedge clk);
        end
        check("R10 address unchanged by busy offer", bad, 0);
        repeat (3) begin
            @(negedge clk);
            if (busy || bus_cs_n != 2'b11) bad = 1;
        end
        check("R10 no cycle from ignored offer", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_m0();
        t_read_byte();
        t_writes();
        t_wait_read();
        t_fast_modes();
        t_watchdog();
        t_busy_ignore();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("[TB] FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule